// File: doc/BRIEF.md
# Two-Wire Serial Token Link Endpoint

This block is one end of a full-duplex serial link built from two unidirectional two-wire channels. Each channel carries tokens on a data wire and a strobe wire. For every bit, exactly one of the two wires changes level. A receiver therefore sees one edge per bit on the exclusive-OR of the two wires, and it needs no clock from the sender. Each token is either a data token (one byte) or a control token (a 2-bit code). The sender adds a type bit and a parity bit to every token.

The outgoing side takes bytes and control codes through a valid/ready handshake. The incoming side stores received tokens in an eight-entry buffer and presents them through a valid/ready handshake. A sticky flag reports parity errors. Credit-based flow control keeps the buffer from overflowing. The receiving end sends a flow-control token when its buffer can take another eight tokens. The sending end delivers buffered tokens only against credit that it holds. Two instances are wired crosswise to make a link. Bit recovery runs in the local clock domain: the incoming wires are synchronized, and each change of their exclusive-OR marks one bit.

Top module: `ds_token_node`

## Requirements
- R1: On the outgoing wires, data and strobe never change in the same cycle. Each bit changes exactly one of them. Both wires hold their level while no token is being sent.
- R2: A token is sent in this order: parity bit, type bit (1 = control), then payload least significant bit first. A data token is 10 bits long and carries 8 payload bits. A control token is 4 bits long and carries a 2-bit code: 00 flow control, 01 end of packet, 10 end of message, 11 escape.
- R3: The parity bit is chosen so that three groups together hold an odd number of ones: the previous token's payload bits, the current parity bit and the current type bit. Before the first token, the previous payload counts as zero ones. On a mismatch the receiver sets `par_err`, and only reset clears it.
- R4: After reset the transmitter holds zero credit. `in_ready` stays low until a flow-control token has arrived on the incoming wires.
- R5: After reset, each endpoint sends one flow-control token that announces its empty buffer. As a result, the peer's `in_ready` rises without any traffic from the user.
- R6: Each received flow-control token grants eight tokens of credit. Every user token sent uses one credit. The transmitter sends nothing from the user without credit, and the receive buffer never overflows.
- R7: Flow-control tokens use no credit and never appear at the token output. When the transmitter reaches a token boundary with a flow-control token pending, that token goes out before any waiting user token.
- R8: Once the receive buffer has room for eight more tokens beyond those already granted, the receiver requests a new flow-control token. As a result, a stalled sender resumes after the consumer drains the buffer.
- R9: Buffered tokens come out in arrival order. `out_ctl` is the type bit. `out_byte` is the data byte for a data token. For a control token it is the code in bits 1:0, with zeros above.
- R10: During and directly after reset, `out_valid`, `par_err`, `in_ready`, `tx_data` and `tx_strobe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock; also the oversampling clock for the incoming wires |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | User token offered for sending |
| in_ready | output | 1 | User token accepted this cycle |
| in_ctl | input | 1 | 1 = control token, 0 = data token |
| in_byte | input | 8 | Data byte, or control code in bits 1:0 |
| tx_data | output | 1 | Outgoing data wire |
| tx_strobe | output | 1 | Outgoing strobe wire |
| rx_data | input | 1 | Incoming data wire |
| rx_strobe | input | 1 | Incoming strobe wire |
| out_valid | output | 1 | Received token available |
| out_ready | input | 1 | Consumer takes the received token |
| out_ctl | output | 1 | Type of the received token |
| out_byte | output | 8 | Payload of the received token |
| par_err | output | 1 | Sticky parity error flag |

## Verification
The assertions rely on four conditions on the inputs. The user never offers control code 00, because that code is reserved for the link's own credit tokens. Each incoming bit holds for at least two local clock cycles. At most one incoming wire changes per bit. The peer sends buffered tokens only against credit this end has granted. The random generator meets these conditions: it draws control codes only from 01 to 11 and mixes them with random bytes. Two identically parameterized endpoints are wired crosswise, so the peer obeys credit by construction. The directed raw-wire driver holds every bit for four cycles and keeps its buffered tokens within the eight that the endpoint grants after reset.

// File: rtl/ds_pkg.sv
// Shared definitions for the two-wire token link: token lengths, control
// codes, the delivered token type and the parity rule.
package ds_pkg;

    localparam int DATA_TOKEN_BITS = 10;
    localparam int CTL_TOKEN_BITS  = 4;

    typedef enum logic [1:0] {
        CODE_FCT = 2'b00,
        CODE_EOP = 2'b01,
        CODE_EOM = 2'b10,
        CODE_ESC = 2'b11
    } ctl_code_e;

    typedef struct packed {
        logic       ctl;
        logic [7:0] val;
    } token_t;

    // Parity bit that makes prior payload ones + parity + type odd.
    function automatic logic parity_bit(input logic prev_pay_par, input logic type_bit);
        return ~(prev_pay_par ^ type_bit);
    endfunction

endpackage

// File: rtl/ds_fifo.sv
// Small first-in first-out token store used as the receive buffer.
// Assumes the writer never pushes when full (guaranteed by link credit)
// and the reader pops only while rd_valid is high.
module ds_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [WIDTH-1:0]           wdata,
    input  logic                       pop,
    output logic                       rd_valid,
    output logic [WIDTH-1:0]           rd_data,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;

    assign rd_valid = (count != '0);
    assign full     = (count == CW'(DEPTH));
    assign rd_data  = mem[rd_ptr];

    // Store written tokens.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
            if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> rd_valid); // R9

endmodule

// File: rtl/ds_tx.sv
// Transmit half: frames user and flow-control tokens, adds parity and
// type bits, and drives them out on the data/strobe wire pair, one bit
// every BIT_DIV cycles. Holds the credit granted by the far receiver.
// Assumes BIT_DIV >= 2 and that the user never offers control code 00.
module ds_tx
    import ds_pkg::*;
#(
    parameter int BIT_DIV    = 4,
    parameter int CREDIT_MAX = 8,
    parameter int GRANT      = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_ctl,
    input  logic [7:0] in_byte,
    input  logic       fct_req,
    output logic       fct_take,
    input  logic       credit_add,
    output logic       tx_data,
    output logic       tx_strobe
);
    localparam int CRW = $clog2(CREDIT_MAX+1);
    localparam int DVW = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;

    logic           busy;
    logic [9:0]     sh;
    logic [3:0]     left;
    logic [DVW-1:0] div;
    logic [CRW-1:0] credit;
    logic           prev_par;
    logic           cur_fct;
    logic           take_user;
    logic           ld_ctl;
    logic [7:0]     ld_pay;
    logic           ld_p;
    logic [9:0]     ld_frame;
    logic [3:0]     ld_len;

    assign fct_take  = !busy && fct_req;
    assign in_ready  = !busy && !fct_req && (credit != '0);
    assign take_user = in_valid && in_ready;

    // Build the next token frame, flow control first.
    always_comb begin
        ld_ctl   = fct_take ? 1'b1 : in_ctl;
        ld_pay   = fct_take ? {6'b0, CODE_FCT} : (in_ctl ? {6'b0, in_byte[1:0]} : in_byte);
        ld_p     = parity_bit(prev_par, ld_ctl);
        ld_frame = ld_ctl ? {6'b0, ld_pay[1:0], 1'b1, ld_p} : {ld_pay, 1'b0, ld_p};
        ld_len   = ld_ctl ? 4'(CTL_TOKEN_BITS) : 4'(DATA_TOKEN_BITS);
    end

    // Shift the frame out, toggling exactly one wire per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            sh        <= '0;
            left      <= '0;
            div       <= '0;
            prev_par  <= 1'b0;
            cur_fct   <= 1'b0;
            tx_data   <= 1'b0;
            tx_strobe <= 1'b0;
        end else if (!busy) begin
            if (fct_take || take_user) begin
                busy     <= 1'b1;
                sh       <= ld_frame;
                left     <= ld_len;
                div      <= '0;
                prev_par <= ^ld_pay;
                cur_fct  <= fct_take;
            end
        end else begin
            if (div == '0) begin
                tx_data <= sh[0];
                if (sh[0] == tx_data) tx_strobe <= ~tx_strobe;
                sh   <= sh >> 1;
                left <= left - 4'd1;
            end
            if (div == DVW'(BIT_DIV-1)) begin
                div <= '0;
                if (left == 4'd0) busy <= 1'b0;
            end else begin
                div <= div + DVW'(1);
            end
        end
    end

    // Credit bookkeeping: grants in, user tokens out.
    always_ff @(posedge clk) begin
        if (!rst_n) credit <= '0;
        else        credit <= credit + (credit_add ? CRW'(GRANT) : '0) - CRW'(take_user);
    end

    AST_ONE_WIRE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !((tx_data != $past(tx_data)) && (tx_strobe != $past(tx_strobe)))); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(tx_data) && $stable(tx_strobe))); // R1
    AST_FCT_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fct_req) |=> (busy && cur_fct)); // R7
    AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        credit <= CRW'(CREDIT_MAX)); // R6
    AST_USER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ctl) |-> (in_byte[1:0] != CODE_FCT)); // R2

endmodule

// File: rtl/ds_rx.sv
// Receive half: synchronizes the wire pair, takes one bit per change of
// data XOR strobe, deframes tokens, checks parity, buffers non-credit
// tokens and asks the local transmitter for flow-control tokens.
// Assumes each incoming bit holds for at least two local cycles.
module ds_rx
    import ds_pkg::*;
#(
    parameter int BUF_DEPTH = 8,
    parameter int GRANT     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_data,
    input  logic       rx_strobe,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       out_ctl,
    output logic [7:0] out_byte,
    output logic       par_err,
    output logic       fct_req,
    input  logic       fct_take,
    output logic       credit_add
);
    localparam int OW = $clog2(BUF_DEPTH+GRANT+1);
    localparam int CW = $clog2(BUF_DEPTH+1);

    logic          d1, d2, s1, s2, x_q;
    logic          bit_evt, bitv;
    logic [3:0]    cnt;
    logic          p_bit, t_bit, prev_par;
    logic [7:0]    pay, pay_full;
    logic [2:0]    pidx;
    logic          done, is_fct, push;
    logic          full;
    logic [CW-1:0] fill;
    logic [OW-1:0] owed;
    logic          room_ok;
    token_t        wr_tok, rd_tok;

    assign bit_evt = ((d2 ^ s2) != x_q);
    assign bitv    = d2;
    assign pidx    = 3'(cnt - 4'd2);
    assign done    = bit_evt && ((t_bit && cnt == 4'd3) || (!t_bit && cnt == 4'd9));
    assign is_fct  = done && t_bit && (pay_full[1:0] == CODE_FCT);
    assign push    = done && !is_fct;
    assign credit_add = is_fct;
    assign room_ok = (OW'(fill) + owed + OW'(GRANT)) <= OW'(BUF_DEPTH);

    // Merge the arriving payload bit into the partial payload.
    always_comb begin
        pay_full       = pay;
        pay_full[pidx] = bitv;
    end

    // Two-stage synchronizer and edge reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d1 <= 1'b0; d2 <= 1'b0; s1 <= 1'b0; s2 <= 1'b0; x_q <= 1'b0;
        end else begin
            d1 <= rx_data; d2 <= d1; s1 <= rx_strobe; s2 <= s1; x_q <= d2 ^ s2;
        end
    end

    // Token deframing and parity check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0; p_bit <= 1'b0; t_bit <= 1'b0; pay <= '0;
            prev_par <= 1'b0; par_err <= 1'b0;
        end else if (bit_evt) begin
            if (cnt == 4'd0) begin
                p_bit <= bitv;
                cnt   <= 4'd1;
            end else if (cnt == 4'd1) begin
                t_bit <= bitv;
                pay   <= '0;
                cnt   <= 4'd2;
                if (!(prev_par ^ p_bit ^ bitv)) par_err <= 1'b1;
            end else begin
                pay <= pay_full;
                if (done) begin
                    cnt      <= '0;
                    prev_par <= ^pay_full;
                end else begin
                    cnt <= cnt + 4'd1;
                end
            end
        end
    end

    // Granted-but-unused credit and flow-control requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed    <= '0;
            fct_req <= 1'b0;
        end else begin
            owed <= owed + (fct_take ? OW'(GRANT) : '0) - OW'(push);
            if (fct_take)                fct_req <= 1'b0;
            else if (!fct_req && room_ok) fct_req <= 1'b1;
        end
    end

    assign wr_tok = '{ctl: t_bit, val: pay_full};

    ds_fifo #(.DEPTH(BUF_DEPTH), .WIDTH(9)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .wdata    (wr_tok),
        .pop      (out_valid && out_ready),
        .rd_valid (out_valid),
        .rd_data  (rd_tok),
        .full     (full),
        .count    (fill)
    );

    assign out_ctl  = rd_tok.ctl;
    assign out_byte = rd_tok.val;

    AST_PUSH_CREDITED: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (owed != '0)); // R6
    AST_BUF_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> par_err); // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fct_req && !fct_take) |=> fct_req); // R8

endmodule

// File: rtl/ds_token_node.sv
// One endpoint of a two-wire token link: a transmitter and a receiver
// sharing credit. The receiver's flow-control requests leave through the
// local transmitter; flow-control tokens it receives grant credit to it.
// Assumes the peer uses the same BIT_DIV-compatible rate and BUF_DEPTH.
module ds_token_node #(
    parameter int BIT_DIV   = 4,
    parameter int BUF_DEPTH = 8,
    parameter int GRANT     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_ctl,
    input  logic [7:0] in_byte,
    output logic       tx_data,
    output logic       tx_strobe,
    input  logic       rx_data,
    input  logic       rx_strobe,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       out_ctl,
    output logic [7:0] out_byte,
    output logic       par_err
);
    logic fct_req, fct_take, credit_add;

    ds_tx #(.BIT_DIV(BIT_DIV), .CREDIT_MAX(BUF_DEPTH), .GRANT(GRANT)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_ctl     (in_ctl),
        .in_byte    (in_byte),
        .fct_req    (fct_req),
        .fct_take   (fct_take),
        .credit_add (credit_add),
        .tx_data    (tx_data),
        .tx_strobe  (tx_strobe)
    );

    ds_rx #(.BUF_DEPTH(BUF_DEPTH), .GRANT(GRANT)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_data    (rx_data),
        .rx_strobe  (rx_strobe),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_ctl    (out_ctl),
        .out_byte   (out_byte),
        .par_err    (par_err),
        .fct_req    (fct_req),
        .fct_take   (fct_take),
        .credit_add (credit_add)
    );

endmodule

// File: tb/ds_token_node_tb.sv
module ds_token_node_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic a_iv = 0, a_ic = 0, a_or = 0; logic [7:0] a_ib = 0;
    logic b_iv = 0, b_ic = 0, b_or = 0; logic [7:0] b_ib = 0;
    logic c_or = 0, c_rd = 0, c_rs = 0;
    logic a_ir, a_ov, a_oc, a_pe, a_td, a_ts; logic [7:0] a_ob;
    logic b_ir, b_ov, b_oc, b_pe, b_td, b_ts; logic [7:0] b_ob;
    logic c_ir, c_ov, c_oc, c_pe, c_td, c_ts; logic [7:0] c_ob;

    ds_token_node u_dut (.clk(clk), .rst_n(rst_n), .in_valid(a_iv), .in_ready(a_ir),
        .in_ctl(a_ic), .in_byte(a_ib), .tx_data(a_td), .tx_strobe(a_ts),
        .rx_data(b_td), .rx_strobe(b_ts), .out_valid(a_ov), .out_ready(a_or),
        .out_ctl(a_oc), .out_byte(a_ob), .par_err(a_pe));
    ds_token_node u_peer (.clk(clk), .rst_n(rst_n), .in_valid(b_iv), .in_ready(b_ir),
        .in_ctl(b_ic), .in_byte(b_ib), .tx_data(b_td), .tx_strobe(b_ts),
        .rx_data(a_td), .rx_strobe(a_ts), .out_valid(b_ov), .out_ready(b_or),
        .out_ctl(b_oc), .out_byte(b_ob), .par_err(b_pe));
    ds_token_node u_raw (.clk(clk), .rst_n(rst_n), .in_valid(1'b0), .in_ready(c_ir),
        .in_ctl(1'b0), .in_byte(8'h00), .tx_data(c_td), .tx_strobe(c_ts),
        .rx_data(c_rd), .rx_strobe(c_rs), .out_valid(c_ov), .out_ready(c_or),
        .out_ctl(c_oc), .out_byte(c_ob), .par_err(c_pe));

    int n_chk = 0, n_bad = 0;
    logic [8:0] q_ab[$];
    logic [8:0] q_ba[$];
    logic a_hold = 1, b_hold = 1;
    int both_tog = 0, edges = 0;
    logic pa_d = 0, pa_s = 0, pb_d = 0, pb_s = 0;
    logic prevp = 0;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Random token: mostly data, control codes 01..11 only (R2, R9).
    function automatic logic [8:0] gen_tok();
        int r = int'($urandom % 8);
        if (r == 0) return {1'b1, 6'b0, 2'(1 + $urandom % 3)};
        return {1'b0, 8'($urandom)};
    endfunction

    // Expected output of a token per R9: type bit, byte or code in low bits.
    function automatic logic [8:0] exp_out(input logic [8:0] t);
        return t[8] ? {1'b1, 6'b0, t[1:0]} : t;
    endfunction

    task automatic push_a(input logic [8:0] t);
        logic r;
        @(negedge clk); a_iv = 1; {a_ic, a_ib} = t;
        forever begin
            #1 r = a_ir;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
        q_ab.push_back(exp_out(t));
    endtask

    task automatic push_b(input logic [8:0] t);
        logic r;
        @(negedge clk); b_iv = 1; {b_ic, b_ib} = t;
        forever begin
            #1 r = b_ir;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
        q_ba.push_back(exp_out(t));
    endtask

    // Consumers with scoreboards (R9).
    always @(negedge clk) begin
        if (rst_n) begin
            b_or = b_hold ? 1'b0 : (($urandom % 4) != 0);
            if (b_or && b_ov) begin
                if (q_ab.size() == 0) check(0, "R9 A->B unexpected", {b_oc, b_ob}, 0);
                else begin
                    check({b_oc, b_ob} == q_ab[0], "R9 A->B order", {b_oc, b_ob}, q_ab[0]);
                    void'(q_ab.pop_front());
                end
            end
            a_or = a_hold ? 1'b0 : (($urandom % 4) != 0);
            if (a_or && a_ov) begin
                if (q_ba.size() == 0) check(0, "R9 B->A unexpected", {a_oc, a_ob}, 0);
                else begin
                    check({a_oc, a_ob} == q_ba[0], "R9 B->A order", {a_oc, a_ob}, q_ba[0]);
                    void'(q_ba.pop_front());
                end
            end
        end
    end

    // Wire monitor for R1.
    always @(negedge clk) begin
        if (rst_n) begin
            if ((a_td != pa_d) && (a_ts != pa_s)) both_tog++;
            if ((b_td != pb_d) && (b_ts != pb_s)) both_tog++;
            if ((a_td != pa_d) || (a_ts != pa_s)) edges++;
        end
        pa_d = a_td; pa_s = a_ts; pb_d = b_td; pb_s = b_ts;
    end

    task automatic raw_bit(input logic b);
        @(negedge clk);
        if (b != c_rd) c_rd = b; else c_rs = ~c_rs;
        repeat (3) @(negedge clk);
    endtask

    // Raw token onto u_raw's wires, parity per R3, order per R2.
    task automatic raw_tok(input logic ctl, input logic [7:0] v, input logic bad);
        logic p;
        int n;
        p = ~(prevp ^ ctl) ^ bad;
        raw_bit(p);
        raw_bit(ctl);
        n = ctl ? 2 : 8;
        for (int i = 0; i < n; i++) raw_bit(v[i]);
        prevp = ctl ? ^v[1:0] : ^v;
    endtask

    task automatic pop_c();
        @(negedge clk); c_or = 1;
        @(negedge clk); c_or = 0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seen;
        int t;
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        // R10 reset state
        check(a_ov == 0 && a_pe == 0 && a_td == 0 && a_ts == 0, "R10 reset outputs",
              {a_ov, a_pe, a_td, a_ts}, 0);
        check(a_ir == 0, "R10 in_ready in reset", a_ir, 0);
        rst_n = 1;
        @(negedge clk);
        check(a_ir == 0, "R4 zero credit after reset", a_ir, 0);

        // R5: peer's announce token grants credit
        t = 0;
        while (!a_ir && t < 300) begin @(negedge clk); t++; end
        check(a_ir == 1, "R5 credit from announce", a_ir, 1);

        // R6: exactly eight tokens against one grant while peer stalls
        for (int i = 0; i < 8; i++) push_a(gen_tok());
        @(negedge clk); a_iv = 0;
        seen = 0;
        for (int i = 0; i < 300; i++) begin @(negedge clk); if (a_ir) seen++; end
        check(seen == 0, "R6 no credit beyond eight", seen, 0);
        check(b_ov == 1, "R6 buffered tokens held", b_ov, 1);

        // R8: draining resumes credit
        b_hold = 0; a_hold = 0;
        t = 0;
        while ((q_ab.size() != 0 || !a_ir) && t < 2000) begin @(negedge clk); t++; end
        check(q_ab.size() == 0, "R9 stalled burst delivered", q_ab.size(), 0);
        check(a_ir == 1, "R8 credit regained", a_ir, 1);

        // Random bidirectional traffic
        fork
            begin for (int i = 0; i < 250; i++) push_a(gen_tok()); @(negedge clk); a_iv = 0; end
            begin for (int i = 0; i < 250; i++) push_b(gen_tok()); @(negedge clk); b_iv = 0; end
        join
        t = 0;
        while ((q_ab.size() != 0 || q_ba.size() != 0) && t < 5000) begin @(negedge clk); t++; end
        check(q_ab.size() == 0 && q_ba.size() == 0, "R9 all tokens delivered",
              q_ab.size() + q_ba.size(), 0);
        check(a_pe == 0 && b_pe == 0, "R3 no parity error on clean link", {a_pe, b_pe}, 0);
        check(both_tog == 0, "R1 one wire per bit", both_tog, 0);
        check(edges > 1000, "R1 wire activity", edges, 1000);

        // Raw-wire framing and parity tests on u_raw
        raw_tok(0, 8'hA5, 0);
        repeat (10) @(negedge clk);
        check(c_ov && {c_oc, c_ob} == 9'h0A5, "R2 data token framing", {c_oc, c_ob}, 9'h0A5);
        pop_c();
        raw_tok(1, 8'h02, 0);
        repeat (10) @(negedge clk);
        check(c_ov && {c_oc, c_ob} == 9'h102, "R2 end-of-message code", {c_oc, c_ob}, 9'h102);
        pop_c();
        raw_tok(1, 8'h01, 0);
        repeat (10) @(negedge clk);
        check(c_ov && {c_oc, c_ob} == 9'h101, "R9 end-of-packet code", {c_oc, c_ob}, 9'h101);
        pop_c();
        check(c_ir == 0, "R4 no credit without flow token", c_ir, 0);
        raw_tok(1, 8'h00, 0);
        repeat (10) @(negedge clk);
        check(c_ov == 0, "R7 flow token not delivered", c_ov, 0);
        check(c_ir == 1, "R6 flow token grants credit", c_ir, 1);
        check(c_pe == 0, "R3 good parity accepted", c_pe, 0);
        raw_tok(0, 8'h5A, 1);
        repeat (10) @(negedge clk);
        check(c_pe == 1, "R3 parity error flagged", c_pe, 1);
        pop_c();
        raw_tok(0, 8'h0F, 0);
        repeat (10) @(negedge clk);
        check(c_pe == 1, "R3 error flag sticky", c_pe, 1);
        check(c_ov && {c_oc, c_ob} == 9'h00F, "R2 framing after bad token", {c_oc, c_ob}, 9'h00F);
        pop_c();
        finish_run();
    end

endmodule